// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-facing controller of a byte-wide memory reached over a two-wire serial bus. It oversamples the clock and data lines with the system clock, recognises START and STOP conditions, and answers to one 7-bit device address. A write transaction loads a two-byte memory address into an auto-incrementing pointer and then stores any number of data bytes. A read transaction streams bytes from the pointer onward for as long as the master acknowledges them.

The storage array sits outside the block. The block presents one address, a write strobe, write data and a read-data return, and it expects the read data to follow the address in the same cycle. Each byte is committed on its eighth bit, so there is no page buffer and no busy state. A write-protect input blocks data writes but still lets the master set the pointer. SDA is driven as an open-drain enable: high means pull the line low.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset, `sda_oe_o` and `mem_we_o` are low and the pointer is 0, so a current-address read returns the byte at address 0.
- R2: A header byte is accepted when bits 7..4 equal 1010 and bits 3..1 equal `sel_i`. Bit 0 selects the direction, with 1 meaning read. An accepted header is acknowledged by pulling SDA low during the ninth clock.
- R3: A header with a wrong device type or wrong select bits gets no acknowledge. SDA then stays released for every following byte until the next START.
- R4: After a write header, the first byte is the address high byte and the second is the low byte. The pointer takes the low `ADDR_W` bits of the 16-bit value formed from them, and the higher bits are ignored. Both address bytes are acknowledged.
- R5: Each data byte of a write is committed on the rising SCL edge of its eighth bit, before the acknowledge. The commit is a single-cycle `mem_we_o` pulse with `mem_addr_o` equal to the pointer. The pointer then increments.
- R6: The pointer wraps from 2^ADDR_W-1 to 0 on both writes and reads.
- R7: While `wp_i` is high, a data byte is not stored and not acknowledged, and the pointer does not move. The slave ignores the rest of that transaction. Address bytes are still acknowledged.
- R8: A read starts at the pointer and sends each byte MSB first. SDA changes only while SCL is low. After each byte the pointer increments and SDA is released for the master's acknowledge. An ACK continues the read with the next byte, and a NACK ends it with SDA released.
- R9: A START at any point aborts the transaction and the slave awaits a header. A write header, two address bytes, a repeated START and a read header together perform a read from any chosen address. A START before the eighth data bit leaves memory unchanged.
- R10: A STOP aborts any transaction and releases SDA. A STOP before the eighth data bit leaves memory and pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sel_i | input | 3 | Device select value compared with header bits 3..1 |
| wp_i | input | 1 | Write protect, high blocks data writes |
| sda_oe_o | output | 1 | Pull SDA low when high |
| mem_addr_o | output | ADDR_W | Array address, equal to the pointer |
| mem_wdata_o | output | 8 | Byte to store |
| mem_we_o | output | 1 | One-cycle store strobe |
| mem_rdata_i | input | 8 | Array read data for `mem_addr_o`, same cycle |

## Verification
The bench builds the block with `ADDR_W` = 4, so the array has 16 locations. This makes it affordable to do a selective read of every address, and to cross a pointer wrap in both a sequential write and a sequential read within a few bytes. It also sweeps every pairing of header select bits with `sel_i` values, and every device-type nibble. Expected data comes from a shadow array that the bench updates only when its own rules say a store should happen.

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter int          ADDR_W   = 15,
  parameter int          SEL_W    = 3,
  parameter logic [3:0]  DEV_TYPE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              wp_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  input  logic [7:0]        mem_rdata_i
);

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_ACK, S_RD, S_MACK
  } state_t;

  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;
  wire        scl_s = scl_sync[1];
  wire        sda_s = sda_sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end

  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  state_t            st, ack_next;
  logic [2:0]        cnt;
  logic [6:0]        sh;
  logic [7:0]        hi_q;
  logic [ADDR_W-1:0] ptr;
  logic              ack_en, ack_live, oe, we, mack;
  logic [7:0]        wdata;

  wire [7:0] rx_byte = {sh, sda_s};
  wire       dev_hit = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[SEL_W:1] == sel_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      ack_next <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      hi_q     <= '0;
      ptr      <= '0;
      ack_en   <= 1'b0;
      ack_live <= 1'b0;
      oe       <= 1'b0;
      we       <= 1'b0;
      mack     <= 1'b0;
      wdata    <= '0;
    end else begin
      we <= 1'b0;
      if (we) ptr <= ptr + ADDR_W'(1);
      if (start_det) begin
        st       <= S_DEV;
        cnt      <= '0;
        oe       <= 1'b0;
        ack_live <= 1'b0;
      end else if (stop_det) begin
        st       <= S_IDLE;
        oe       <= 1'b0;
        ack_live <= 1'b0;
      end else begin
        case (st)
          S_DEV, S_AHI, S_ALO, S_WR:
            if (scl_rise) begin
              sh  <= rx_byte[6:0];
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                st       <= S_ACK;
                ack_live <= 1'b0;
                ack_en   <= 1'b1;
                case (st)
                  S_DEV: begin
                    ack_en   <= dev_hit;
                    ack_next <= !dev_hit ? S_IDLE : (rx_byte[0] ? S_RD : S_AHI);
                  end
                  S_AHI: begin
                    hi_q     <= rx_byte;
                    ack_next <= S_ALO;
                  end
                  S_ALO: begin
                    ptr      <= ADDR_W'({hi_q, rx_byte});
                    ack_next <= S_WR;
                  end
                  default: begin
                    ack_en   <= !wp_i;
                    ack_next <= wp_i ? S_IDLE : S_WR;
                    we       <= !wp_i;
                    wdata    <= rx_byte;
                  end
                endcase
              end
            end
          S_ACK:
            if (scl_fall) begin
              if (!ack_live) begin
                ack_live <= 1'b1;
                oe       <= ack_en;
              end else begin
                ack_live <= 1'b0;
                st       <= ack_next;
                cnt      <= '0;
                if (ack_next == S_RD) begin
                  sh <= mem_rdata_i[6:0];
                  oe <= ~mem_rdata_i[7];
                end else begin
                  oe <= 1'b0;
                end
              end
            end
          S_RD:
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                oe  <= 1'b0;
                st  <= S_MACK;
                ptr <= ptr + ADDR_W'(1);
              end else begin
                cnt <= cnt + 3'd1;
                sh  <= {sh[5:0], 1'b0};
                oe  <= ~sh[6];
              end
            end
          S_MACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              if (mack) begin
                st  <= S_RD;
                cnt <= '0;
                sh  <= mem_rdata_i[6:0];
                oe  <= ~mem_rdata_i[7];
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end

  assign sda_oe_o    = oe;
  assign mem_addr_o  = ptr;
  assign mem_wdata_o = wdata;
  assign mem_we_o    = we;

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe_o);
  assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));
  assert_wp_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_i && st == S_WR && scl_rise && cnt == 3'd7) |=> !mem_we_o);
  assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_s);
  assert_start_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_DEV && !sda_oe_o));
  assert_stop_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE && !sda_oe_o));

endmodule

// File: tb/tb_twowire_mem_slave.sv
module tb_twowire_mem_slave;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] sel = 3'b101;
  logic sda_oe, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem [N];
  logic [7:0] exp_mem [N];
  wire  sda_line = sda_m & ~sda_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  twowire_mem_slave #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sel_i(sel),
    .wp_i(wp), .sda_oe_o(sda_oe), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem[mem_addr]));

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 37 + 5);
  endfunction

  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= init_val(i);
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic b_start();
    sda_m = 1'b1; w(4); scl = 1'b1; w(8); sda_m = 1'b0; w(8); scl = 1'b0; w(4);
  endtask

  task automatic b_stop();
    scl = 1'b0; w(4); sda_m = 1'b0; w(4); scl = 1'b1; w(8); sda_m = 1'b1; w(8);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      w(4); sda_m = b[i]; w(4); scl = 1'b1; w(8); scl = 1'b0;
    end
  endtask

  task automatic wbyte(logic [7:0] b, output bit acked);
    send_bits(b, 8);
    w(4); sda_m = 1'b1; w(4); scl = 1'b1; w(4);
    acked = (sda_line == 1'b0);
    w(4); scl = 1'b0;
  endtask

  task automatic rbyte(bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(8); scl = 1'b1; w(4); b[i] = sda_line; w(4); scl = 1'b0;
    end
    w(4); sda_m = ~give_ack; w(4); scl = 1'b1; w(8); scl = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] rb;
    for (int i = 0; i < N; i++) exp_mem[i] = init_val(i);
    w(5); rst_n = 1'b1; w(5);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 mem_we after reset", int'(mem_we), 0);

    b_start(); wbyte(8'hAB, a); chk("R2 read header ack", int'(a), 1);
    rbyte(1'b0, rb); b_stop();
    chk("R1 first read at address 0", int'(rb), int'(exp_mem[0]));

    for (int s = 0; s < 8; s++)
      for (int h = 0; h < 8; h++) begin
        sel = 3'(s);
        b_start(); wbyte({4'b1010, 3'(h), 1'b0}, a); b_stop();
        chk(h == s ? "R2 select match ack" : "R3 select mismatch nack", int'(a), int'(h == s));
      end
    sel = 3'b101;
    for (int t = 0; t < 16; t++) begin
      b_start(); wbyte({4'(t), 3'b101, 1'b0}, a); b_stop();
      chk(t == 10 ? "R2 type match ack" : "R3 type mismatch nack", int'(a), int'(t == 10));
    end
    b_start(); wbyte(8'h3A, a); wbyte(8'h00, a); b_stop();
    chk("R3 silent after mismatch", int'(a), 0);

    b_start(); wbyte(8'hAA, a); wbyte(8'hFF, a); chk("R4 high byte ack", int'(a), 1);
    wbyte(8'hFE, a); chk("R4 low byte ack", int'(a), 1);
    for (int k = 0; k < 4; k++) begin
      wbyte(8'(17 * (k + 1)), a);
      chk("R5 data ack", int'(a), 1);
      exp_mem[(14 + k) % N] = 8'(17 * (k + 1));
    end
    b_stop();
    for (int k = 0; k < 4; k++)
      chk("R6 write across wrap", int'(mem[(14 + k) % N]), int'(exp_mem[(14 + k) % N]));
    b_start(); wbyte(8'hAB, a); rbyte(1'b0, rb); b_stop();
    chk("R6 pointer after write wrap", int'(rb), int'(exp_mem[2]));

    for (int ad = 0; ad < N; ad++) begin
      b_start(); wbyte(8'hAA, a); wbyte(8'h5A, a); wbyte(8'(ad | (ad << 4)), a);
      b_start(); wbyte(8'hAB, a); rbyte(1'b0, rb); b_stop();
      chk("R9 selective read", int'(rb), int'(exp_mem[ad]));
    end

    b_start(); wbyte(8'hAA, a); wbyte(8'h00, a); wbyte(8'h0D, a);
    b_start(); wbyte(8'hAB, a);
    for (int k = 0; k < 5; k++) begin
      rbyte(k != 4, rb);
      chk("R8 sequential read wrap R6", int'(rb), int'(exp_mem[(13 + k) % N]));
    end
    w(6); chk("R8 released after nack", int'(sda_oe), 0);
    b_stop();

    wp = 1'b1;
    b_start(); wbyte(8'hAA, a); wbyte(8'h00, a); wbyte(8'h05, a);
    chk("R7 address acked under protect", int'(a), 1);
    wbyte(8'h99, a); chk("R7 data nack under protect", int'(a), 0);
    wbyte(8'h98, a); chk("R7 later byte nack", int'(a), 0);
    b_stop(); wp = 1'b0;
    chk("R7 memory unchanged", int'(mem[5]), int'(exp_mem[5]));
    b_start(); wbyte(8'hAB, a); rbyte(1'b0, rb); b_stop();
    chk("R7 pointer frozen", int'(rb), int'(exp_mem[5]));

    b_start(); wbyte(8'hAA, a); wbyte(8'h00, a); wbyte(8'h07, a);
    send_bits(8'h00, 5); b_stop();
    chk("R10 stop abort keeps memory", int'(mem[7]), int'(exp_mem[7]));
    b_start(); wbyte(8'hAB, a); rbyte(1'b0, rb); b_stop();
    chk("R10 stop abort keeps pointer", int'(rb), int'(exp_mem[7]));

    b_start(); wbyte(8'hAA, a); wbyte(8'h00, a); wbyte(8'h08, a);
    send_bits(8'hFF, 4);
    b_start(); wbyte(8'hAB, a); chk("R9 header after abort ack", int'(a), 1);
    rbyte(1'b0, rb); b_stop();
    chk("R9 start abort read", int'(rb), int'(exp_mem[8]));
    chk("R9 start abort keeps memory", int'(mem[8]), int'(exp_mem[8]));

    for (int i = 0; i < N; i++) chk("R5 final array", int'(mem[i]), int'(exp_mem[i]));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule